// File: doc/BRIEF.md
# Balanced 4-to-10 Line Codec with Single-Error Correction

This block holds an encoder and a decoder for a line code that turns every 4-bit nibble into a 10-bit codeword. Every codeword carries equal numbers of ones and zeros, so the line stays DC balanced. Runs of equal bits are short enough to keep a downstream clock recovery circuit locked. The set of codewords has a minimum Hamming distance of four, so the receive side can repair one flipped bit and can report two flipped bits as uncorrectable.

Each codeword is built from five two-bit symbols. One symbol comes from each data bit, and a fifth symbol comes from the even parity of the nibble. A symbol value of one is sent as `10` and a value of zero as `01`. The parity makes any two words differ in at least two symbols, which is four line bits. The decoder measures the distance from the received word to all sixteen codewords in parallel. A comparison tree then selects the nearest one, and the result lands in one output register. Both directions use valid/ready streams, and each side has a single output register.

Top module: `balanced_line_codec`

## Requirements
- R1: The codeword for nibble d is made of five bit pairs. Pair [9:8] carries d[3], [7:6] carries d[2], [5:4] carries d[1], [3:2] carries d[0], and [1:0] carries d[0]^d[1]^d[2]^d[3]. A carried value of 1 becomes 2'b10 and a value of 0 becomes 2'b01.
- R2: Every codeword the encoder emits holds exactly five ones and five zeros.
- R3: No codeword has three equal adjacent bits. If any single bit of a codeword is inverted, the longest run of equal bits is at most five.
- R4: Any two distinct codewords differ in four or more bit positions.
- R5: The encoder accepts a nibble when enc_in_valid and enc_in_ready are both high. enc_in_ready is high exactly when the output register is empty or enc_out_ready is high. The codeword is presented on the cycle after acceptance and is held unchanged while enc_out_ready is low.
- R6: When the decoder receives an exact codeword, it returns the matching nibble with both flags low, one cycle after acceptance.
- R7: When the received word is at distance 1 from a codeword, the decoder returns that codeword's nibble, raises dec_out_corrected and keeps dec_out_uncorrectable low.
- R8: When the smallest distance to any codeword is 2 or more, the decoder raises dec_out_uncorrectable and keeps dec_out_corrected low. dec_out_data is then the lowest-numbered nibble whose codeword is at that smallest distance. This covers every two-bit error.
- R9: The decoder follows the same handshake and hold rules as R5, using its own dec_* ports.
- R10: While rst is high on a clock edge, both output valids are low on the next cycle and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Nibble available to the encoder |
| enc_in_ready | output | 1 | Encoder can take a nibble |
| enc_in_data | input | 4 | Nibble to encode |
| enc_out_valid | output | 1 | Codeword available |
| enc_out_ready | input | 1 | Consumer takes the codeword |
| enc_out_code | output | 10 | Encoded word |
| dec_in_valid | input | 1 | Received word available |
| dec_in_ready | output | 1 | Decoder can take a word |
| dec_in_code | input | 10 | Received word |
| dec_out_valid | output | 1 | Decoded result available |
| dec_out_ready | input | 1 | Consumer takes the result |
| dec_out_data | output | 4 | Decoded nibble |
| dec_out_corrected | output | 1 | One bit was repaired |
| dec_out_uncorrectable | output | 1 | Nearest codeword at distance two or more |

## Verification
Both the codeword and the decoded result appear exactly one clock after the word is accepted. The bench drives each item on a falling edge, lets one rising edge capture it, and reads the output on the next falling edge, which is the first point where the registered result is visible. In the stall sequence the bench holds the consumer's ready low across several edges. It checks on each of those falling edges that the output and the input ready do not move. Once ready is released, it expects the queued item after exactly one more edge.

// File: rtl/lc10_pkg.sv
package lc10_pkg;

  // Builds the codeword for value 'data' on 'dw' data bits.
  // Pair j (bits 2j+1:2j) carries data bit j-1; pair 0 carries the even parity.
  function automatic logic [63:0] build_code(input int data, input int dw);
    logic [63:0] cw;
    logic        par;
    logic        b;
    cw  = '0;
    par = 1'b0;
    for (int i = 0; i < dw; i++) par = par ^ data[i];
    for (int j = 0; j <= dw; j++) begin
      b = (j == 0) ? par : data[j-1];
      cw[2*j+1] = b;
      cw[2*j]   = ~b;
    end
    return cw;
  endfunction

  function automatic int count_ones(input logic [63:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int longest_run(input logic [63:0] v, input int w);
    int best;
    int cur;
    best = 1;
    cur  = 1;
    for (int i = 1; i < w; i++) begin
      cur  = (v[i] == v[i-1]) ? cur + 1 : 1;
      best = (cur > best) ? cur : best;
    end
    return best;
  endfunction

endpackage

// File: rtl/lc10_encoder.sv
module lc10_encoder #(
  parameter int DATA_W = 4,
  localparam int CODE_W = 2 * (DATA_W + 1),
  localparam int NUM_WORDS = 1 << DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code
);
  logic [CODE_W-1:0] code_rom [NUM_WORDS];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_rom
    localparam logic [63:0] ENTRY = lc10_pkg::build_code(k, DATA_W);
    assign code_rom[k] = ENTRY[CODE_W-1:0];
  end

  logic              valid_q;
  logic [CODE_W-1:0] code_q;
  logic              take;

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      if (take) code_q <= code_rom[in_data];
      if (in_ready) valid_q <= in_valid;
    end
  end

  assign out_valid = valid_q;
  assign out_code  = code_q;

  assert_enc_balanced_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (lc10_pkg::count_ones(64'(out_code)) == CODE_W / 2));

  assert_enc_short_runs_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (lc10_pkg::longest_run(64'(out_code), CODE_W) <= 2));

  assert_enc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

  assert_enc_reset_R10: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: rtl/lc10_min_tree.sv
module lc10_min_tree #(
  parameter int LEAVES = 16,
  parameter int DIST_W = 4,
  localparam int IDX_W = $clog2(LEAVES),
  localparam int LEVELS = $clog2(LEAVES)
) (
  input  logic [LEAVES*DIST_W-1:0] dist_flat,
  output logic [DIST_W-1:0]        min_dist,
  output logic [IDX_W-1:0]         min_idx
);
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int NODES = LEAVES >> l;
    logic [DIST_W-1:0] d  [NODES];
    logic [IDX_W-1:0]  ix [NODES];
    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < NODES; k++) begin : g_in
        assign d[k]  = dist_flat[k*DIST_W +: DIST_W];
        assign ix[k] = IDX_W'(k);
      end
    end else begin : g_cmp
      for (genvar k = 0; k < NODES; k++) begin : g_node
        logic hi_wins;
        // Ties keep the lower-indexed side.
        assign hi_wins = g_lvl[l-1].d[2*k+1] < g_lvl[l-1].d[2*k];
        assign d[k]  = hi_wins ? g_lvl[l-1].d[2*k+1]  : g_lvl[l-1].d[2*k];
        assign ix[k] = hi_wins ? g_lvl[l-1].ix[2*k+1] : g_lvl[l-1].ix[2*k];
      end
    end
  end

  assign min_dist = g_lvl[LEVELS].d[0];
  assign min_idx  = g_lvl[LEVELS].ix[0];
endmodule

// File: rtl/lc10_decoder.sv
module lc10_decoder #(
  parameter int DATA_W = 4,
  localparam int CODE_W = 2 * (DATA_W + 1),
  localparam int NUM_WORDS = 1 << DATA_W,
  localparam int DIST_W = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_corrected,
  output logic              out_uncorrectable
);
  logic [NUM_WORDS*DIST_W-1:0] dist_flat;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_dist
    localparam logic [63:0] ENTRY = lc10_pkg::build_code(k, DATA_W);
    assign dist_flat[k*DIST_W +: DIST_W] =
      DIST_W'(lc10_pkg::count_ones(64'(in_code ^ ENTRY[CODE_W-1:0])));
  end

  logic [DIST_W-1:0] best_dist;
  logic [DATA_W-1:0] best_idx;

  lc10_min_tree #(.LEAVES(NUM_WORDS), .DIST_W(DIST_W)) u_tree (
    .dist_flat(dist_flat),
    .min_dist (best_dist),
    .min_idx  (best_idx)
  );

  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              corr_q;
  logic              unc_q;
  logic              take;

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      corr_q  <= 1'b0;
      unc_q   <= 1'b0;
    end else begin
      if (take) begin
        data_q <= best_idx;
        corr_q <= (best_dist == DIST_W'(1));
        unc_q  <= (best_dist >= DIST_W'(2));
      end
      if (in_ready) valid_q <= in_valid;
    end
  end

  assign out_valid         = valid_q;
  assign out_data          = data_q;
  assign out_corrected     = corr_q;
  assign out_uncorrectable = unc_q;

  assert_dec_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({out_corrected, out_uncorrectable}));

  assert_dec_exact_clean_R6: assert property (@(posedge clk) disable iff (rst)
    (take && best_dist == '0) |=> (!out_corrected && !out_uncorrectable));

  assert_dec_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
      && $stable(out_corrected) && $stable(out_uncorrectable)));

  assert_dec_reset_R10: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: rtl/balanced_line_codec.sv
module balanced_line_codec #(
  parameter int DATA_W = 4,
  localparam int CODE_W = 2 * (DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [DATA_W-1:0] enc_in_data,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [CODE_W-1:0] enc_out_code,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [CODE_W-1:0] dec_in_code,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [DATA_W-1:0] dec_out_data,
  output logic              dec_out_corrected,
  output logic              dec_out_uncorrectable
);
  lc10_encoder #(.DATA_W(DATA_W)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .in_valid (enc_in_valid),
    .in_ready (enc_in_ready),
    .in_data  (enc_in_data),
    .out_valid(enc_out_valid),
    .out_ready(enc_out_ready),
    .out_code (enc_out_code)
  );

  lc10_decoder #(.DATA_W(DATA_W)) u_dec (
    .clk              (clk),
    .rst              (rst),
    .in_valid         (dec_in_valid),
    .in_ready         (dec_in_ready),
    .in_code          (dec_in_code),
    .out_valid        (dec_out_valid),
    .out_ready        (dec_out_ready),
    .out_data         (dec_out_data),
    .out_corrected    (dec_out_corrected),
    .out_uncorrectable(dec_out_uncorrectable)
  );
endmodule

// File: tb/balanced_line_codec_bench.sv
`timescale 1ns/1ps
module balanced_line_codec_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_in_valid = 1'b0;
  logic       enc_in_ready;
  logic [3:0] enc_in_data = '0;
  logic       enc_out_valid;
  logic       enc_out_ready = 1'b1;
  logic [9:0] enc_out_code;
  logic       dec_in_valid = 1'b0;
  logic       dec_in_ready;
  logic [9:0] dec_in_code = '0;
  logic       dec_out_valid;
  logic       dec_out_ready = 1'b1;
  logic [3:0] dec_out_data;
  logic       dec_out_corrected;
  logic       dec_out_uncorrectable;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [9:0] seen [16];

  always #2 clk = ~clk;

  balanced_line_codec u_balanced_line_codec (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference codeword from the R1 pair rule.
  function automatic logic [9:0] ref_code(input int n);
    logic [9:0] c;
    logic p;
    p = n[0] ^ n[1] ^ n[2] ^ n[3];
    c[1:0] = p ? 2'b10 : 2'b01;
    for (int b = 0; b < 4; b++) c[2*b+3 -: 2] = n[b] ? 2'b10 : 2'b01;
    return c;
  endfunction

  function automatic int ones10(input logic [9:0] v);
    int s = 0;
    for (int i = 0; i < 10; i++) if (v[i]) s++;
    return s;
  endfunction

  function automatic int run10(input logic [9:0] v);
    int r = 1, m = 1;
    for (int i = 1; i < 10; i++) begin
      if (v[i] == v[i-1]) r++; else r = 1;
      if (r > m) m = r;
    end
    return m;
  endfunction

  task automatic dec_one(input logic [9:0] w, input string tag);
    int bd = 99, bi = 0, d;
    for (int k = 0; k < 16; k++) begin
      d = ones10(w ^ ref_code(k));
      if (d < bd) begin bd = d; bi = k; end
    end
    @(negedge clk);
    dec_in_code = w; dec_in_valid = 1'b1;
    @(negedge clk);
    dec_in_valid = 1'b0;
    check(dec_out_valid === 1'b1, {tag, " valid"}, int'(dec_out_valid), 1);
    check(dec_out_data == 4'(bi), {tag, " data"}, int'(dec_out_data), bi);
    check(dec_out_corrected == (bd == 1), {tag, " corrected"},
          int'(dec_out_corrected), int'(bd == 1));
    check(dec_out_uncorrectable == (bd >= 2), {tag, " uncorrectable"},
          int'(dec_out_uncorrectable), int'(bd >= 2));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(enc_out_valid == 1'b0, "R10 enc valid", int'(enc_out_valid), 0);
    check(dec_out_valid == 1'b0, "R10 dec valid", int'(dec_out_valid), 0);
    check(enc_in_ready == 1'b1, "R10 enc ready", int'(enc_in_ready), 1);
    check(dec_in_ready == 1'b1, "R10 dec ready", int'(dec_in_ready), 1);
    rst = 1'b0;

    // R1, R2, R3: every nibble through the encoder
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      enc_in_data = 4'(n); enc_in_valid = 1'b1;
      @(negedge clk);
      enc_in_valid = 1'b0;
      seen[n] = enc_out_code;
      check(enc_out_valid && enc_out_code == ref_code(n), "R1 codeword",
            int'(enc_out_code), int'(ref_code(n)));
      check(ones10(enc_out_code) == 5, "R2 balance", ones10(enc_out_code), 5);
      check(run10(enc_out_code) <= 2, "R3 run", run10(enc_out_code), 2);
      for (int f = 0; f < 10; f++) begin
        logic [9:0] x;
        x = enc_out_code ^ (10'd1 << f);
        check(run10(x) <= 5, "R3 flipped run", run10(x), 5);
      end
    end
    // R4 pairwise distance on emitted words
    for (int a = 0; a < 16; a++)
      for (int b = a + 1; b < 16; b++)
        check(ones10(seen[a] ^ seen[b]) >= 4, "R4 distance",
              ones10(seen[a] ^ seen[b]), 4);

    // R6, R7, R8: 0-, 1- and 2-bit errors on every codeword
    for (int n = 0; n < 16; n++) begin
      dec_one(ref_code(n), "R6 clean");
      for (int i = 0; i < 10; i++) begin
        dec_one(ref_code(n) ^ (10'd1 << i), "R7 single");
        for (int j = i + 1; j < 10; j++)
          dec_one(ref_code(n) ^ (10'd1 << i) ^ (10'd1 << j), "R8 double");
      end
    end
    // R8: a word far from every codeword
    dec_one(10'h000, "R8 all zero");

    // R5 encoder stall and release
    @(negedge clk);
    enc_out_ready = 1'b0; enc_in_data = 4'h9; enc_in_valid = 1'b1;
    @(negedge clk);
    enc_in_data = 4'h6;
    for (int c = 0; c < 3; c++) begin
      check(enc_out_valid && enc_out_code == ref_code(9), "R5 hold",
            int'(enc_out_code), int'(ref_code(9)));
      check(enc_in_ready == 1'b0, "R5 ready low", int'(enc_in_ready), 0);
      @(negedge clk);
    end
    enc_out_ready = 1'b1;
    @(negedge clk);
    enc_in_valid = 1'b0;
    check(enc_out_valid && enc_out_code == ref_code(6), "R5 release",
          int'(enc_out_code), int'(ref_code(6)));
    @(negedge clk);
    check(enc_out_valid == 1'b0, "R5 drain", int'(enc_out_valid), 0);

    // R9 decoder stall and release
    dec_out_ready = 1'b0; dec_in_code = ref_code(3) ^ 10'h010; dec_in_valid = 1'b1;
    @(negedge clk);
    dec_in_code = ref_code(12);
    for (int c = 0; c < 3; c++) begin
      check(dec_out_valid && dec_out_data == 4'd3 && dec_out_corrected,
            "R9 hold", int'(dec_out_data), 3);
      check(dec_in_ready == 1'b0, "R9 ready low", int'(dec_in_ready), 0);
      @(negedge clk);
    end
    dec_out_ready = 1'b1;
    @(negedge clk);
    dec_in_valid = 1'b0;
    check(dec_out_valid && dec_out_data == 4'd12 && !dec_out_corrected,
          "R9 release", int'(dec_out_data), 12);

    done = 1;
    summary();
    $finish;
  end
endmodule